// File: doc/BRIEF.md
# Vector Element Multiply-Add Lane

This block is one element lane of a vector integer multiply unit. Each cycle it may accept one element: two sources (`src_a` and `src_b`, or a scalar `src_scalar` standing in for `src_b`), the current destination value `dst_old`, a 4-bit operation code, and a mask bit. It returns one result element a cycle later.

The supported operations are:

- the low product;
- the high half of the product, in three signedness flavours;
- the double-width product, in three flavours;
- the two single-width fused forms;
- the double-width accumulate, in three flavours.

Operand routing depends on the operation code. In the accumulate form the two sources are multiplied and the old destination is added. In the multiply-add form the old destination is a multiplicand and `src_a` becomes the addend.

Signedness also depends on the operation code. The mixed-sign product forms treat `src_a` as signed and `src_b` as unsigned. The mixed-sign double-width accumulate reverses those roles.

Every operand is extended by one bit beyond double width, with sign or zero fill as the operation requires. One signed multiplier then covers all signedness combinations.

Top module: `vmac_lane`

## Requirements
- R1: `res_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. While `in_valid` is low, `res_data` keeps its previous value and all other inputs are ignored.
- R2: Code 0 returns the low SEW bits of `src_a`×`src_b` in `res_data[SEW-1:0]`. For codes 0, 1, 2, 3, 7 and 8, the upper SEW bits of `res_data` are zero.
- R3: Codes 1, 2 and 3 return the upper SEW bits of the 2×SEW-bit product. Code 1 treats both sources as signed, code 2 treats both as unsigned, and code 3 treats `src_a` as signed and `src_b` as unsigned.
- R4: Codes 4, 5 and 6 return the full 2×SEW-bit product. Code 4 is signed×signed, code 5 is unsigned×unsigned, and code 6 is `src_a` signed × `src_b` unsigned.
- R5: Code 7 (accumulate) returns (`src_b`×`src_a` + `dst_old[SEW-1:0]`) modulo 2^SEW, with no saturation.
- R6: Code 8 (multiply-add) returns (`src_b`×`dst_old[SEW-1:0]` + `src_a`) modulo 2^SEW. Here the old destination is a multiplicand and `src_a` is the addend.
- R7: Codes 9, 10 and 11 return (product + `dst_old`) modulo 2^(2×SEW), using the full 2×SEW-bit `dst_old`. Code 9 is signed×signed and code 10 is unsigned×unsigned. Code 11 treats `src_b` as signed and `src_a` as unsigned.
- R8: With `use_scalar` high, `src_scalar` replaces `src_b` in every operation, including its signedness role.
- R9: When `mask_on` is 1 and `mask_bit` is 0, the accepted element returns `dst_old` unchanged. When `mask_on` is 0, `mask_bit` has no effect.
- R10: Codes 12 to 15 are reserved. An unmasked element with one of these codes returns zero.
- R11: While `rst_n` is low, `res_valid` and `res_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Element accepted this cycle |
| op_code | input | 4 | Operation select (see R2 to R7, R10) |
| use_scalar | input | 1 | Take `src_scalar` in place of `src_b` |
| src_a | input | SEW | First vector source |
| src_b | input | SEW | Second vector source |
| src_scalar | input | SEW | Scalar source |
| dst_old | input | 2×SEW | Current destination value |
| mask_on | input | 1 | Masking enabled |
| mask_bit | input | 1 | Element mask bit |
| res_valid | output | 1 | Result valid |
| res_data | output | 2×SEW | Result element |

## Verification
On every cycle the assertions check the following:

- the one-cycle valid timing and the hold of `res_data` when idle;
- the pass-through of `dst_old` for masked-off elements;
- the zero upper half of narrow results and the zero result for reserved codes;
- the sign fill applied to each multiplier operand, including the reversed roles of the mixed-sign accumulate;
- the fact that double-width products never need the guard bit.

The arithmetic values themselves are shown only by the bench's scenarios. These run every code against a wide-integer reference using extreme operands: the most negative value, all ones and the largest positive value. They also cover scalar substitution and masking with each setting of the mask controls.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

  typedef enum logic [3:0] {
    OP_MUL      = 4'd0,
    OP_MULH_SS  = 4'd1,
    OP_MULH_UU  = 4'd2,
    OP_MULH_SU  = 4'd3,
    OP_WMUL_SS  = 4'd4,
    OP_WMUL_UU  = 4'd5,
    OP_WMUL_SU  = 4'd6,
    OP_ACC      = 4'd7,
    OP_MADD     = 4'd8,
    OP_WACC_SS  = 4'd9,
    OP_WACC_UU  = 4'd10,
    OP_WACC_SU  = 4'd11
  } vmac_op_e;

  typedef enum logic [2:0] {
    RK_NONE, RK_LOW, RK_HIGH, RK_WIDE, RK_ACC, RK_WACC
  } res_kind_e;

  // How the product is turned into a result
  function automatic res_kind_e kind_of(logic [3:0] op);
    case (op)
      OP_MUL:                             return RK_LOW;
      OP_MULH_SS, OP_MULH_UU, OP_MULH_SU: return RK_HIGH;
      OP_WMUL_SS, OP_WMUL_UU, OP_WMUL_SU: return RK_WIDE;
      OP_ACC, OP_MADD:                    return RK_ACC;
      OP_WACC_SS, OP_WACC_UU, OP_WACC_SU: return RK_WACC;
      default:                            return RK_NONE;
    endcase
  endfunction

  function automatic logic both_unsigned(logic [3:0] op);
    return (op == OP_MULH_UU) || (op == OP_WMUL_UU) || (op == OP_WACC_UU);
  endfunction

  // Signedness of the multiplicand taken from src_a (or dst_old for multiply-add)
  function automatic logic a_side_signed(logic [3:0] op);
    return !(both_unsigned(op) || (op == OP_WACC_SU));
  endfunction

  // Signedness of the multiplicand taken from src_b / src_scalar
  function automatic logic b_side_signed(logic [3:0] op);
    return !(both_unsigned(op) || (op == OP_MULH_SU) || (op == OP_WMUL_SU));
  endfunction

endpackage

// File: rtl/vmac_route.sv
module vmac_route
  import vmac_pkg::*;
#(
  parameter int SEW = 16
) (
  input  logic [3:0]              op_code,
  input  logic                    use_scalar,
  input  logic [SEW-1:0]          src_a,
  input  logic [SEW-1:0]          src_b,
  input  logic [SEW-1:0]          src_scalar,
  input  logic [2*SEW-1:0]        dst_old,
  output logic signed [2*SEW:0]   mul_x,
  output logic signed [2*SEW:0]   mul_y,
  output logic [2*SEW-1:0]        addend
);
  localparam int DW = 2 * SEW;
  localparam int XW = DW + 1;

  function automatic logic signed [XW-1:0] extend(logic [SEW-1:0] v, logic sg);
    return {{(SEW + 1){sg & v[SEW-1]}}, v};
  endfunction

  logic [SEW-1:0] b_src;
  logic [SEW-1:0] x_src;
  logic           is_madd;
  logic           is_wacc;

  assign b_src   = use_scalar ? src_scalar : src_b;
  assign is_madd = (op_code == OP_MADD);
  assign is_wacc = (kind_of(op_code) == RK_WACC);
  // multiply-add: the old destination is the multiplicand, src_a the addend
  assign x_src   = is_madd ? dst_old[SEW-1:0] : src_a;

  always_comb begin
    mul_x = extend(x_src, a_side_signed(op_code));
    mul_y = extend(b_src, b_side_signed(op_code));
    if (is_madd)      addend = {{SEW{1'b0}}, src_a};
    else if (is_wacc) addend = dst_old;
    else              addend = {{SEW{1'b0}}, dst_old[SEW-1:0]};
  end
endmodule

// File: rtl/vmac_mul.sv
module vmac_mul #(
  parameter int XW = 33
) (
  input  logic signed [XW-1:0] mul_x,
  input  logic signed [XW-1:0] mul_y,
  output logic signed [XW-1:0] prod
);
  // Only the low XW bits are ever needed: the widest result is XW-1 bits
  assign prod = mul_x * mul_y;
endmodule

// File: rtl/vmac_post.sv
module vmac_post
  import vmac_pkg::*;
#(
  parameter int SEW = 16
) (
  input  res_kind_e         kind,
  input  logic [2*SEW-1:0]  prod_lo,
  input  logic [2*SEW-1:0]  addend,
  output logic [2*SEW-1:0]  result
);
  logic [SEW-1:0] narrow_sum;
  assign narrow_sum = prod_lo[SEW-1:0] + addend[SEW-1:0];

  always_comb begin
    case (kind)
      RK_LOW:  result = {{SEW{1'b0}}, prod_lo[SEW-1:0]};
      RK_HIGH: result = {{SEW{1'b0}}, prod_lo[2*SEW-1:SEW]};
      RK_WIDE: result = prod_lo;
      RK_ACC:  result = {{SEW{1'b0}}, narrow_sum};
      RK_WACC: result = prod_lo + addend;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
  import vmac_pkg::*;
#(
  parameter int SEW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [3:0]          op_code,
  input  logic                use_scalar,
  input  logic [SEW-1:0]      src_a,
  input  logic [SEW-1:0]      src_b,
  input  logic [SEW-1:0]      src_scalar,
  input  logic [2*SEW-1:0]    dst_old,
  input  logic                mask_on,
  input  logic                mask_bit,
  output logic                res_valid,
  output logic [2*SEW-1:0]    res_data
);
  localparam int DW = 2 * SEW;
  localparam int XW = DW + 1;

  logic signed [XW-1:0] mul_x;
  logic signed [XW-1:0] mul_y;
  logic signed [XW-1:0] prod;
  logic [DW-1:0]        addend;
  logic [DW-1:0]        result;
  res_kind_e            kind;
  logic                 masked_off;
  logic                 b_neg;
  logic                 is_wide;

  assign kind       = kind_of(op_code);
  assign masked_off = mask_on & ~mask_bit;
  assign b_neg      = use_scalar ? src_scalar[SEW-1] : src_b[SEW-1];
  assign is_wide    = (kind == RK_WIDE) || (kind == RK_WACC);

  vmac_route #(.SEW(SEW)) route_i (
    .op_code(op_code), .use_scalar(use_scalar), .src_a(src_a), .src_b(src_b),
    .src_scalar(src_scalar), .dst_old(dst_old),
    .mul_x(mul_x), .mul_y(mul_y), .addend(addend)
  );

  vmac_mul #(.XW(XW)) mul_i (.mul_x(mul_x), .mul_y(mul_y), .prod(prod));

  vmac_post #(.SEW(SEW)) post_i (
    .kind(kind), .prod_lo(prod[DW-1:0]), .addend(addend), .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_data <= masked_off ? dst_old : result;
    end
  end

  // ---------------- assertions ----------------
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_data)));
  assert_mask_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_on && !mask_bit) |=> (res_data == $past(dst_old)));
  assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !masked_off && (kind == RK_LOW || kind == RK_HIGH || kind == RK_ACC))
      |=> (res_data[DW-1:SEW] == '0));
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !masked_off && op_code >= 4'd12) |=> (res_data == '0));
  assert_uu_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && both_unsigned(op_code)) |-> (!mul_x[XW-1] && !mul_y[XW-1]));
  assert_su_roles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_code == OP_MULH_SU || op_code == OP_WMUL_SU))
      |-> (mul_x[XW-1] == src_a[SEW-1] && !mul_y[XW-1]));
  assert_su_roles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == OP_WACC_SU) |-> (!mul_x[XW-1] && mul_y[XW-1] == b_neg));
  assert_prod_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_wide) |->
      (both_unsigned(op_code) ? !prod[XW-1] : (prod[XW-1] == prod[DW-1])));
endmodule

// File: tb/vmac_lane_tb_top.sv
`timescale 1ns/1ps
module vmac_lane_tb_top;
  localparam int SEW = 16;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [3:0]    op_code = '0;
  logic          use_scalar = 1'b0;
  logic [SEW-1:0] src_a = '0, src_b = '0, src_scalar = '0;
  logic [DW-1:0] dst_old = '0;
  logic          mask_on = 1'b0, mask_bit = 1'b0;
  logic          res_valid;
  logic [DW-1:0] res_data;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  live = 1'b0;
  logic          exp_v = 1'b0;
  logic [DW-1:0] exp_d = '0;
  string         exp_tag = "R11";

  always #4 clk = ~clk;

  vmac_lane #(.SEW(SEW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .use_scalar(use_scalar), .src_a(src_a), .src_b(src_b), .src_scalar(src_scalar),
    .dst_old(dst_old), .mask_on(mask_on), .mask_bit(mask_bit),
    .res_valid(res_valid), .res_data(res_data)
  );

  // Wide-integer reference: a = src_a, b = selected second source
  function automatic logic [DW-1:0] model(logic [3:0] op, logic [15:0] a, logic [15:0] b,
                                          logic [31:0] d, bit mon, bit mb);
    longint sa = longint'($signed(a));
    longint ua = longint'(a);
    longint sb = longint'($signed(b));
    longint ub = longint'(b);
    longint dl = longint'(d[15:0]);
    longint df = longint'(d);
    longint r;
    if (mon && !mb) return d;
    case (op)
      4'd0:  r = (ua * ub) & 64'hFFFF;
      4'd1:  r = ((sa * sb) >>> 16) & 64'hFFFF;
      4'd2:  r = ((ua * ub) >>> 16) & 64'hFFFF;
      4'd3:  r = ((sa * ub) >>> 16) & 64'hFFFF;
      4'd4:  r = (sa * sb) & 64'hFFFF_FFFF;
      4'd5:  r = (ua * ub) & 64'hFFFF_FFFF;
      4'd6:  r = (sa * ub) & 64'hFFFF_FFFF;
      4'd7:  r = (ub * ua + dl) & 64'hFFFF;
      4'd8:  r = (ub * dl + ua) & 64'hFFFF;
      4'd9:  r = (sb * sa + df) & 64'hFFFF_FFFF;
      4'd10: r = (ub * ua + df) & 64'hFFFF_FFFF;
      4'd11: r = (sb * ua + df) & 64'hFFFF_FFFF;
      default: r = 0;
    endcase
    return r[31:0];
  endfunction

  function automatic string tag_of(logic [3:0] op, bit sc, bit mon, bit mb);
    string t;
    if (mon && !mb) return "R9 masked";
    case (op)
      4'd0: t = "R2"; 4'd1, 4'd2, 4'd3: t = "R3"; 4'd4, 4'd5, 4'd6: t = "R4";
      4'd7: t = "R5"; 4'd8: t = "R6"; 4'd9, 4'd10, 4'd11: t = "R7";
      default: t = "R10";
    endcase
    if (sc) t = {"R8 ", t};
    if (mon) t = {t, " R9 enabled"};
    return t;
  endfunction

  // cycle model
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v <= 1'b0; exp_d <= '0; exp_tag <= "R11";
    end else begin
      exp_v <= in_valid;
      if (in_valid) begin
        exp_d   <= model(op_code, src_a, use_scalar ? src_scalar : src_b, dst_old, mask_on, mask_bit);
        exp_tag <= tag_of(op_code, use_scalar, mask_on, mask_bit);
      end else begin
        exp_tag <= "R1 idle";
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      n_checks++;
      if (res_valid !== exp_v || res_data !== exp_d) begin
        n_fail++;
        $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                 exp_tag, res_valid, res_data, exp_v, exp_d);
      end
    end
  end

  task automatic send(logic [3:0] op, bit sc, logic [15:0] a, logic [15:0] b,
                      logic [15:0] s, logic [31:0] d, bit mon, bit mb);
    @(negedge clk);
    in_valid = 1'b1; op_code = op; use_scalar = sc; src_a = a; src_b = b;
    src_scalar = s; dst_old = d; mask_on = mon; mask_bit = mb;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; op_code = 4'($urandom); use_scalar = 1'($urandom);
    src_a = 16'($urandom); src_b = 16'($urandom); src_scalar = 16'($urandom);
    dst_old = $urandom; mask_on = 1'($urandom); mask_bit = 1'($urandom);
  endtask

  initial begin
    logic [15:0] cv [6];
    cv = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    // R11 reset state
    repeat (3) begin
      @(negedge clk);
      n_checks++;
      if (res_valid !== 1'b0 || res_data !== '0) begin
        n_fail++;
        $display("FAIL R11: valid=%0b data=%h expected valid=0 data=0", res_valid, res_data);
      end
    end
    rst_n = 1'b1;
    live = 1'b1;
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 6; i++)
        send(4'(op), 0, cv[i], cv[(i + 2) % 6], cv[(i + 4) % 6],
             {cv[(i + 1) % 6], cv[(i + 3) % 6]}, 0, 0);
      send(4'(op), 0, 16'h8000, 16'h8000, 16'h0, 32'hFFFF_FFFF, 0, 0);
      send(4'(op), 0, 16'hFFFF, 16'hFFFF, 16'h0, 32'h8000_0000, 0, 0);
      send(4'(op), 0, 16'h8000, 16'hFFFF, 16'h0, 32'h7FFF_8000, 0, 0);
      send(4'(op), 0, 16'hFFFF, 16'h8000, 16'h0, 32'h0000_FFFF, 0, 0);
      for (int k = 0; k < 3; k++)
        send(4'(op), 0, 16'($urandom), 16'($urandom), 16'($urandom), $urandom, 0, 0);
      // R8 scalar replaces src_b
      send(4'(op), 1, 16'h8000, 16'h0003, 16'hFFFF, 32'h1357_9BDF, 0, 0);
      send(4'(op), 1, 16'($urandom), 16'($urandom), 16'h8000, $urandom, 0, 0);
      // R9 masked off, then masking disabled with mask bit 0
      send(4'(op), 0, 16'hFFFF, 16'h8000, 16'h0, 32'hDEAD_BEEF, 1, 0);
      send(4'(op), 0, 16'hFFFF, 16'h8000, 16'h0, 32'hDEAD_BEEF, 0, 0);
      send(4'(op), 0, 16'h7FFF, 16'h8000, 16'h0, 32'h0123_4567, 1, 1);
      // R1 idle cycles with changing inputs
      idle();
      idle();
    end
    idle();
    idle();
    live = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: cycles=200000 expected completion earlier");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule